// File: doc/BRIEF.md
# Byte-Serial Port with Status Interrupt

This block is a byte-wide asynchronous serial port reached through a three-location register window. Writing the data location places a byte in a transmit holding register. The byte moves into a shift register and leaves on `txLine` as a frame: one start bit, eight data bits least significant first, and one stop bit. Each bit lasts `16*TICK_DIV` clocks. Reading the data location returns the last byte received on `rxLine`. The receiver takes three samples near the middle of each bit and uses their majority.

A control location holds a break-forcing bit and two interrupt enables. A status location reports whether the transmitter is empty, whether data is waiting, and whether a framing error, break or overrun was seen. One active-high interrupt output comes with an output-enable. When neither interrupt source is enabled, the output-enable drops, so the pin can be released to a pull-up.

Top module: `serial_port`

## Requirements
- R1: After reset, status reads 0xC0, control reads 0x00, `txLine` is high, and `irqOe` and `irqOut` are low.
- R2: Offset 0 is data, offset 1 is control and offset 2 is status. Offset 3 reads 0. In control, bit 7 forces break, bit 6 enables the transmit-empty interrupt, bit 5 enables the receive-ready interrupt, and bits 4..0 read 0. In status, bit 7 is transmitter empty (TEMT), bit 6 is holding empty (THRE), bit 3 is break, bit 2 is framing error, bit 1 is overrun and bit 0 is data ready. Bits 5..4 read 0.
- R3: Each transmitted frame is a low start bit, the eight data bits LSB first, and a high stop bit. Each bit lasts 16*TICK_DIV clocks.
- R4: A data write clears TEMT and THRE on the next edge. The held byte moves into the shift register one clock after the shifter is idle, and THRE then returns to 1. TEMT returns to 1 when the frame ends. TEMT never reads 1 while THRE is 0.
- R5: A data write while THRE is 0 replaces the held byte, and the replaced byte is never sent.
- R6: Each received bit is the majority of three samples near mid-bit, so a one-clock glitch does not corrupt a byte. A low pulse shorter than half a bit is rejected as a false start and produces no data.
- R7: A completed frame loads the receive buffer and sets data ready. A data read returns the byte and clears data ready.
- R8: A frame whose stop bit is 0 sets framing error. If its data bits are also all 0, it also sets break.
- R9: A frame that completes while data ready is set sets overrun, and the new byte replaces the old one.
- R10: A status read clears break, framing error and overrun, but leaves data ready set.
- R11: While control bit 7 is 1, `txLine` is held low.
- R12: `irqOut` is (bit 6 AND THRE) OR (bit 5 AND data ready). `irqOe` is bit 6 OR bit 5. When `irqOe` is low, `irqOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register offset |
| wrEn | input | 1 | Write strobe, one cycle per access |
| rdEn | input | 1 | Read strobe, one cycle per access (triggers read side effects) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| rxLine | input | 1 | Serial receive line, idle high |
| txLine | output | 1 | Serial transmit line, idle high |
| irqOut | output | 1 | Interrupt request, active high |
| irqOe | output | 1 | Output-enable for the interrupt pin |

## Verification
The bench loops the transmitter back into the receiver and sends all 256 byte values. A swapped bit order, an off-by-one bit count or a wrong sample point would corrupt some of those values. Back-to-back writes probe the hand-off from the holding register to the shifter. A design that loses the hand-off edge, or that sends the byte a later write replaced, would receive the wrong sequence of bytes. The bench also drives hand-built frames with glitches, zero stop bits, all-zero data and short low pulses. A receiver without majority voting would return altered bytes, and one with no start-bit check would report data that was never sent. Flag-clearing order is checked with repeated status and data reads: if data ready is cleared by a status read, or overrun survives one, a status value comes back wrong.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef struct packed {
    logic holdLoad;  // capture wrData into the holding register
    logic txStart;   // move holding register into the shifter
  } ctlStrobes_t;

  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;
  localparam logic [1:0] OFS_STAT = 2'd2;
endpackage

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  addr,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic        txBusy,
  input  logic        rxDone,
  input  logic [7:0]  rxByte,
  input  logic        rxFrameErr,
  input  logic        rxBreak,
  output logic        sendBreak,
  output logic        irqOut,
  output logic        irqOe,
  output ctlStrobes_t strobes
);
  logic enTx, enRx, holdValid;
  logic dataReady, overrun, frameErr, breakSeen;
  logic wrDataSel, wrCtrlSel, rdDataSel, rdStatSel;
  logic thre, temt;

  assign wrDataSel = wrEn && (addr == OFS_DATA);
  assign wrCtrlSel = wrEn && (addr == OFS_CTRL);
  assign rdDataSel = rdEn && (addr == OFS_DATA);
  assign rdStatSel = rdEn && (addr == OFS_STAT);

  assign strobes.holdLoad = wrDataSel;
  assign strobes.txStart  = holdValid && !txBusy;

  assign thre = !holdValid;
  assign temt = !holdValid && !txBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sendBreak <= 1'b0;
      enTx      <= 1'b0;
      enRx      <= 1'b0;
    end else if (wrCtrlSel) begin
      sendBreak <= wrData[7];
      enTx      <= wrData[6];
      enRx      <= wrData[5];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdValid <= 1'b0;
    else if (wrDataSel) holdValid <= 1'b1;
    else if (strobes.txStart) holdValid <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReady <= 1'b0;
      overrun   <= 1'b0;
      frameErr  <= 1'b0;
      breakSeen <= 1'b0;
    end else begin
      if (rxDone) dataReady <= 1'b1;
      else if (rdDataSel) dataReady <= 1'b0;

      if (rxDone && dataReady && !rdDataSel) overrun <= 1'b1;
      else if (rdStatSel) overrun <= 1'b0;

      if (rxDone && rxFrameErr) frameErr <= 1'b1;
      else if (rdStatSel) frameErr <= 1'b0;

      if (rxDone && rxBreak) breakSeen <= 1'b1;
      else if (rdStatSel) breakSeen <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr)
      OFS_DATA: rdData = rxByte;
      OFS_CTRL: rdData = {sendBreak, enTx, enRx, 5'b0};
      OFS_STAT: rdData = {temt, thre, 2'b0, breakSeen, frameErr, overrun, dataReady};
      default:  rdData = 8'h00;
    endcase
  end

  assign irqOe  = enTx || enRx;
  assign irqOut = (enTx && thre) || (enRx && dataReady);
endmodule

// File: rtl/sp_datapath.sv
module sp_datapath
  import sp_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  input  logic [7:0]  wrData,
  input  logic        sendBreak,
  input  logic        rxLine,
  output logic        txLine,
  output logic        txBusy,
  output logic        rxDone,
  output logic        rxFrameErr,
  output logic        rxBreak,
  output logic [7:0]  rxByte
);
  localparam int OVS        = 16;
  localparam int BIT_CLKS   = OVS * TICK_DIV;
  localparam int BIT_W      = $clog2(BIT_CLKS);
  localparam int FRAME_BITS = 10;
  localparam logic [3:0] START_OFS = 4'd1;  // absorbs synchronizer latency
  localparam logic [3:0] SMP_A = 4'd7;
  localparam logic [3:0] SMP_B = 4'd8;
  localparam logic [3:0] SMP_C = 4'd9;
  localparam logic [3:0] STOP_IDX = 4'd9;

  // ---------------- transmit ----------------
  logic [7:0]       holdByte;
  logic [9:0]       txShift;
  logic [BIT_W-1:0] txCnt;
  logic [3:0]       bitsLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdByte <= 8'h00;
    else if (strobes.holdLoad) holdByte <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '1;
      txCnt    <= '0;
      bitsLeft <= '0;
    end else if (strobes.txStart) begin
      txShift  <= {1'b1, holdByte, 1'b0};
      txCnt    <= '0;
      bitsLeft <= 4'(FRAME_BITS);
    end else if (bitsLeft != 4'd0) begin
      if (txCnt == BIT_W'(BIT_CLKS - 1)) begin
        txCnt    <= '0;
        txShift  <= {1'b1, txShift[9:1]};
        bitsLeft <= bitsLeft - 4'd1;
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  assign txBusy = (bitsLeft != 4'd0);
  assign txLine = !sendBreak && txShift[0];

  // ---------------- receive ----------------
  logic [1:0] rxSync;
  logic       rxPrev, rxS, rxActive, tick;
  logic [3:0] tickCnt, bitIdx;
  logic       voteA, voteB, maj;
  logic [7:0] rxData, rxBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync <= 2'b11;
      rxPrev <= 1'b1;
    end else begin
      rxSync <= {rxSync[0], rxLine};
      rxPrev <= rxSync[1];
    end
  end
  assign rxS = rxSync[1];

  generate
    if (TICK_DIV == 1) begin : g_tickEvery
      assign tick = 1'b1;
    end else begin : g_tickDiv
      localparam int DIV_W = $clog2(TICK_DIV);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) divCnt <= '0;
        else if (!rxActive || divCnt == DIV_W'(TICK_DIV - 1)) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end
      assign tick = (divCnt == DIV_W'(TICK_DIV - 1));
    end
  endgenerate

  assign maj = (voteA && voteB) || (voteA && rxS) || (voteB && rxS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      tickCnt  <= '0;
      bitIdx   <= '0;
      voteA    <= 1'b1;
      voteB    <= 1'b1;
      rxData   <= '0;
    end else if (!rxActive) begin
      if (rxPrev && !rxS) begin
        rxActive <= 1'b1;
        tickCnt  <= START_OFS;
        bitIdx   <= '0;
      end
    end else if (tick) begin
      tickCnt <= tickCnt + 4'd1;
      if (tickCnt == SMP_A) voteA <= rxS;
      if (tickCnt == SMP_B) voteB <= rxS;
      if (tickCnt == SMP_C) begin
        bitIdx <= bitIdx + 4'd1;
        if (bitIdx == 4'd0 && maj) rxActive <= 1'b0;      // false start
        else if (bitIdx == STOP_IDX) rxActive <= 1'b0;    // frame done
        else if (bitIdx != 4'd0) rxData <= {maj, rxData[7:1]};
      end
    end
  end

  assign rxDone     = rxActive && tick && (tickCnt == SMP_C) && (bitIdx == STOP_IDX);
  assign rxFrameErr = !maj;
  assign rxBreak    = !maj && (rxData == 8'h00);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxBuf <= 8'h00;
    else if (rxDone) rxBuf <= rxData;
  end
  assign rxByte = rxBuf;
endmodule

// File: rtl/serial_port.sv
module serial_port
  import sp_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] addr,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       rxLine,
  output logic       txLine,
  output logic       irqOut,
  output logic       irqOe
);
  ctlStrobes_t strobes;
  logic txBusy, rxDone, rxFrameErr, rxBreak, sendBreak;
  logic [7:0] rxByte;

  sp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .txBusy(txBusy), .rxDone(rxDone),
    .rxByte(rxByte), .rxFrameErr(rxFrameErr), .rxBreak(rxBreak),
    .sendBreak(sendBreak), .irqOut(irqOut), .irqOe(irqOe), .strobes(strobes)
  );

  sp_datapath #(.TICK_DIV(TICK_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .sendBreak(sendBreak), .rxLine(rxLine), .txLine(txLine), .txBusy(txBusy),
    .rxDone(rxDone), .rxFrameErr(rxFrameErr), .rxBreak(rxBreak), .rxByte(rxByte)
  );
endmodule

// File: rtl/sp_chk.sv
module sp_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] addr,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       txLine,
  input logic       irqOut,
  input logic       irqOe,
  input logic       txStart,
  input logic       txBusy
);
  // R12
  irq_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqOe |-> !irqOut);

  // R11
  break_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd1 && wrData[7]) |=> !txLine);

  // R4
  shift_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> txBusy);

  // R4
  temt_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd2 && txBusy) |-> !rdData[7]);

  // R2
  ctrl_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd1) |-> (rdData[4:0] == 5'd0));

  // R2
  stat_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd2) |-> (rdData[5:4] == 2'd0 && (!rdData[7] || rdData[6])));
endmodule

bind serial_port sp_chk u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .txLine(txLine), .irqOut(irqOut), .irqOe(irqOe),
  .txStart(strobes.txStart), .txBusy(txBusy)
);

// File: tb/tb_serial_port.sv
module tb_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 1;
  localparam int BIT        = 16 * TICK_DIV;
  localparam int MAX_CYCLES = 150000;

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] addr = 2'd0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = 8'h00, rdData;
  logic benchRx = 1'b1, loopOn = 1'b0;
  logic rxLine, txLine, irqOut, irqOe;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  assign rxLine = loopOn ? txLine : benchRx;

  serial_port #(.TICK_DIV(TICK_DIV)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .rxLine(rxLine), .txLine(txLine),
    .irqOut(irqOut), .irqOe(irqOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic expectRead(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    busRead(a, d);
    check(req, {24'd0, d}, {24'd0, exp});
  endtask

  // Frame driven by the bench on rxLine; optional one-clock glitch mid-bit.
  task automatic sendFrame(input logic [7:0] b, input logic stopBit, input bit glitch);
    logic [9:0] f;
    f = {stopBit, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      benchRx = f[i];
      for (int c = 0; c < BIT; c++) begin
        @(negedge clk);
        benchRx = (glitch && c == BIT/2 - 1) ? ~f[i] : f[i];
      end
    end
    benchRx = 1'b1;
    waitCycles(2 * BIT);
  endtask

  // Capture a transmitted frame at mid-bit points.
  task automatic captureTx(output logic [9:0] f);
    int guard;
    guard = 0;
    while (txLine !== 1'b0 && guard < 4 * BIT) begin @(negedge clk); guard++; end
    waitCycles(BIT/2);
    for (int i = 0; i < 10; i++) begin
      f[i] = txLine;
      if (i < 9) waitCycles(BIT);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    logic [9:0] fr;
    logic [7:0] tv [5];
    tv = '{8'h00, 8'hFF, 8'hA5, 8'h01, 8'h80};
    waitCycles(3);
    @(negedge clk); rstN = 1'b1;
    waitCycles(2);

    // R1 reset state
    expectRead("R1", 2'd2, 8'hC0);
    expectRead("R1", 2'd1, 8'h00);
    check("R1", {31'd0, txLine}, 32'd1);
    check("R1", {30'd0, irqOe, irqOut}, 32'd0);

    // R2 map and reserved bits
    busWrite(2'd1, 8'h1F);
    expectRead("R2", 2'd1, 8'h00);
    busWrite(2'd1, 8'h60);
    expectRead("R2", 2'd1, 8'h60);
    busWrite(2'd1, 8'h00);
    expectRead("R2", 2'd3, 8'h00);

    // R3 bit-level frame shape
    foreach (tv[k]) begin
      busWrite(2'd0, tv[k]);
      captureTx(fr);
      check("R3", {22'd0, fr}, {22'd0, 1'b1, tv[k], 1'b0});
      waitCycles(2 * BIT);
    end

    // R4 holding/shift hand-off timing
    loopOn = 1'b1;
    busWrite(2'd0, 8'h3C);
    expectRead("R4", 2'd2, 8'h00);
    expectRead("R4", 2'd2, 8'h40);
    waitCycles(11 * BIT);
    expectRead("R4", 2'd2, 8'hC1);
    expectRead("R7", 2'd0, 8'h3C);

    // R3 R7 loopback sweep of every byte value
    for (int v = 0; v < 256; v++) begin
      busWrite(2'd0, 8'(v));
      waitCycles(11 * BIT);
      expectRead("R7", 2'd2, 8'hC1);
      expectRead("R3", 2'd0, 8'(v));
    end
    expectRead("R7", 2'd2, 8'hC0);

    // R5 overwrite of held byte
    busWrite(2'd0, 8'h11);
    busWrite(2'd0, 8'h22);
    busWrite(2'd0, 8'h33);
    expectRead("R5", 2'd2, 8'h00);
    waitCycles(11 * BIT);
    expectRead("R5", 2'd0, 8'h11);
    waitCycles(11 * BIT);
    expectRead("R5", 2'd0, 8'h33);
    waitCycles(11 * BIT);
    expectRead("R5", 2'd2, 8'hC0);

    // R9 R10 overrun
    busWrite(2'd0, 8'h5E);
    busWrite(2'd0, 8'hA1);
    waitCycles(22 * BIT);
    expectRead("R9", 2'd2, 8'hC3);
    expectRead("R9", 2'd0, 8'hA1);
    expectRead("R10", 2'd2, 8'hC0);

    // R11 R8 forced break looped back
    busWrite(2'd1, 8'h80);
    check("R11", {31'd0, txLine}, 32'd0);
    waitCycles(12 * BIT);
    check("R11", {31'd0, txLine}, 32'd0);
    busWrite(2'd1, 8'h00);
    waitCycles(2 * BIT);
    expectRead("R8", 2'd2, 8'hCD);
    expectRead("R10", 2'd2, 8'hC1);
    expectRead("R8", 2'd0, 8'h00);
    loopOn = 1'b0;

    // R8 framing error without break
    sendFrame(8'h5A, 1'b0, 1'b0);
    expectRead("R8", 2'd2, 8'hC5);
    expectRead("R10", 2'd2, 8'hC1);
    expectRead("R8", 2'd0, 8'h5A);
    // R8 all-zero frame from the line
    sendFrame(8'h00, 1'b0, 1'b0);
    expectRead("R8", 2'd2, 8'hCD);
    expectRead("R8", 2'd0, 8'h00);

    // R6 glitches tolerated
    foreach (tv[k]) begin
      sendFrame(tv[k] ^ 8'h3C, 1'b1, 1'b1);
      expectRead("R6", 2'd2, 8'hC1);
      expectRead("R6", 2'd0, tv[k] ^ 8'h3C);
    end
    // R6 false start rejected
    benchRx = 1'b0; waitCycles(3); benchRx = 1'b1;
    waitCycles(12 * BIT);
    expectRead("R6", 2'd2, 8'hC0);

    // R12 interrupt behaviour
    loopOn = 1'b1;
    busWrite(2'd1, 8'h40);
    check("R12", {30'd0, irqOe, irqOut}, 32'd3);
    busWrite(2'd0, 8'h77);
    check("R12", {30'd0, irqOe, irqOut}, 32'd2);
    busWrite(2'd1, 8'h20);
    check("R12", {30'd0, irqOe, irqOut}, 32'd2);
    waitCycles(11 * BIT);
    check("R12", {30'd0, irqOe, irqOut}, 32'd3);
    expectRead("R12", 2'd0, 8'h77);
    check("R12", {30'd0, irqOe, irqOut}, 32'd2);
    busWrite(2'd1, 8'h00);
    check("R12", {30'd0, irqOe, irqOut}, 32'd0);

    finish();
  end
endmodule